// File: doc/BRIEF.md
# Sector Write and Verify Controller

This block sits on the host side of a parallel, page-programmed non-volatile memory. It drives the memory's address, write data, chip enable, output enable and write strobe, and it reads the memory's data lines. Software first fills a small local buffer through a load port, one byte per cycle at a chosen offset. It then pulses `start` with a sector base address. The controller writes the three-byte unlock sequence that arms one protected sector write. It streams the buffered bytes back to back, so the memory never sees a long pause between bytes. It then repeatedly reads the last byte written until the memory returns that byte unchanged, with a watchdog guarding the loop. Finally it reads back the whole sector and compares every byte.

When `id_en` is high at start, the controller first asks the memory for its identity. It writes the identification-entry sequence, waits a fixed settling time and reads the device code at address 1. It picks the sector size from that code and leaves identification mode before the protected write begins. The chosen size is kept for later operations. Each operation ends with `done` high, plus one of two error flags or neither. A verify mismatch also reports the offset of the first bad byte.

Top module: `sector_prog_ctrl`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all high. `busy`, `done`, `err_timeout` and `err_verify` reset to 0.
- R2: The first three bus writes of a protected sector write are, in order, data 0xAA to address 0x5555, data 0x55 to address 0x2AAA and data 0xA0 to address 0x5555. They precede every sector byte.
- R3: Sector byte k (k from 0 to size-1, ascending) is written to address `(base_addr & ~(size-1)) | k`, carrying the byte loaded at buffer offset k. Each offset is written exactly once. The sector size resets to DEF_SECT.
- R4: A write cycle drives `mem_we_n` low for exactly PULSE_CYC consecutive cycles while `mem_ce_n` is low and `mem_oe_n` is high. Address and write data stay stable while `mem_we_n` is low and in the cycle it rises.
- R5: Between two consecutive sector byte writes, `mem_we_n` is high for at most 4 cycles.
- R6: After the last sector byte, the controller polls by reading only the address of the last byte written. It leaves polling only when the data read equals the byte written there.
- R7: After a successful poll, every sector byte is read back. If all match, `done` rises with both error flags low and `busy` low.
- R8: On the first verify mismatch, the controller stops with `done` and `err_verify` high, and `fail_off` holds that byte's offset.
- R9: If polling has not succeeded WD_CYC cycles after it starts, the controller stops with `done` and `err_timeout` high. This happens no earlier than WD_CYC cycles after the last sector write, and the bus is idle (R1).
- R10: With `id_en` high at start, the controller writes 0xAA@0x5555, 0x55@0x2AAA, 0x90@0x5555. It waits TWC_CYC cycles and reads address 1. It sets size to 4, 8 or 16 for code bits [1:0] = 0, 1, or 2/3 (capped at BUF_DEPTH). It then writes 0xAA@0x5555, 0x55@0x2AAA, 0xF0@0x5555 before the R2 sequence. The size persists for later starts with `id_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one byte into the local buffer |
| ld_off | input | $clog2(BUF_DEPTH) | Buffer offset for the load |
| ld_data | input | DW | Byte to load |
| start | input | 1 | Begin an operation (accepted only when idle) |
| id_en | input | 1 | Run device identification first |
| base_addr | input | AW | Any address inside the target sector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished (held until next start) |
| err_timeout | output | 1 | Polling watchdog expired |
| err_verify | output | 1 | Read-back mismatch |
| fail_off | output | $clog2(BUF_DEPTH) | Offset of first mismatching byte |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Data driven to the memory |
| mem_din | input | DW | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
The hardest situations to reach are the ones where polling sees a changing answer. The memory must return inverted data while it is busy and true data only once programming commits. It must also stay busy forever for the watchdog path. The bench therefore models the memory behaviourally. The model decodes the command sequences, collects the sector bytes after arming and starts programming after an idle gap. It returns data with bit 7 inverted for a settable number of cycles. Fault knobs in the model corrupt chosen read-back bytes, stretch programming beyond the watchdog and set the device code, so the verify error, timeout and each identification size are driven through the normal ports.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_TWC, S_IDRD, S_LOAD, S_PCHK, S_PRD, S_VRF
    } sp_state_e;

    typedef enum logic [1:0] {
        K_UNLOCK, K_ID_ON, K_ID_OFF
    } cmd_kind_e;

    typedef enum logic [1:0] {
        B_IDLE, B_SETUP, B_STROBE, B_HOLD
    } bus_state_e;

endpackage

// File: rtl/sprog_bus_cycle.sv
module sprog_bus_cycle
    import sprog_pkg::*;
#(
    parameter int AW        = 15,
    parameter int DW        = 8,
    parameter int PULSE_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] dout,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          cyc_done,
    output logic [DW-1:0] rdata
);
    localparam int PW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        bus_state_e    st;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [PW-1:0] cnt;
        logic [DW-1:0] rdata;
    } bus_t;

    bus_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            B_IDLE: if (go) begin
                d.st   = B_SETUP;
                d.wr   = wr_i;
                d.addr = addr_i;
                d.data = wdata_i;
            end
            B_SETUP: begin
                d.st  = B_STROBE;
                d.cnt = PW'(PULSE_CYC - 1);
            end
            B_STROBE: begin
                if (q.cnt == '0) begin
                    d.st = B_HOLD;
                    if (!q.wr) d.rdata = din;
                end else begin
                    d.cnt = q.cnt - PW'(1);
                end
            end
            default: d.st = B_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: B_IDLE, default: '0};
        else        q <= d;
    end

    assign addr_o   = q.addr;
    assign dout     = q.data;
    assign ce_n     = (q.st == B_IDLE);
    assign we_n     = !(q.wr && q.st == B_STROBE);
    assign oe_n     = !(!q.wr && (q.st == B_SETUP || q.st == B_STROBE));
    assign cyc_done = (q.st == B_HOLD);
    assign rdata    = q.rdata;
endmodule

// File: rtl/sprog_timer.sv
module sprog_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [TW-1:0] load,
    output logic          expired
);
    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.run = 1'b1;
            d.cnt = load;
        end else if (stop) begin
            d.run = 1'b0;
        end else if (q.run && q.cnt != '0) begin
            d.cnt = q.cnt - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = q.run && (q.cnt == '0) && !start;
endmodule

// File: rtl/sprog_sector_buf.sv
module sprog_sector_buf #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int OW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [OW-1:0] ld_off,
    input  logic [DW-1:0] ld_data,
    input  logic [OW-1:0] rd_off,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)                                  cell_q[g] <= '0;
            else if (ld_en && ld_off == OW'(g))          cell_q[g] <= ld_data;
        end
    end

    assign rd_data = cell_q[rd_off];
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl
    import sprog_pkg::*;
#(
    parameter int AW        = 15,
    parameter int DW        = 8,
    parameter int BUF_DEPTH = 16,
    parameter int DEF_SECT  = 8,
    parameter int PULSE_CYC = 3,
    parameter int TWC_CYC   = 50,
    parameter int WD_CYC    = 4000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_en,
    input  logic [$clog2(BUF_DEPTH)-1:0] ld_off,
    input  logic [DW-1:0]                ld_data,
    input  logic                         start,
    input  logic                         id_en,
    input  logic [AW-1:0]                base_addr,
    output logic                         busy,
    output logic                         done,
    output logic                         err_timeout,
    output logic                         err_verify,
    output logic [$clog2(BUF_DEPTH)-1:0] fail_off,
    output logic [AW-1:0]                mem_addr,
    output logic [DW-1:0]                mem_dout,
    input  logic [DW-1:0]                mem_din,
    output logic                         mem_ce_n,
    output logic                         mem_oe_n,
    output logic                         mem_we_n
);
    localparam int OW   = $clog2(BUF_DEPTH);
    localparam int SW   = $clog2(BUF_DEPTH + 1);
    localparam int TMAX = (WD_CYC > TWC_CYC) ? WD_CYC : TWC_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        sp_state_e     st;
        cmd_kind_e     kind;
        logic [OW-1:0] idx;
        logic [SW-1:0] size;
        logic [AW-1:0] base;
        logic          go;
        logic          tstart;
        logic          tstop;
        logic [TW-1:0] tload;
        logic          busy;
        logic          done;
        logic          err_to;
        logic          err_vf;
        logic [OW-1:0] fail_off;
    } ctl_t;

    ctl_t q, d;

    logic          b_done, b_wr, t_exp;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_data, b_rdata, buf_rd;
    logic [OW-1:0] last_off, rd_off;
    logic          load_follow;

    function automatic logic [SW-1:0] size_from_code(input logic [1:0] code);
        int s;
        case (code)
            2'd0:    s = 4;
            2'd1:    s = 8;
            default: s = 16;
        endcase
        if (s > BUF_DEPTH) s = BUF_DEPTH;
        return SW'(s);
    endfunction

    function automatic logic [AW-1:0] sect_addr(input logic [AW-1:0] base,
                                                input logic [SW-1:0] size,
                                                input logic [OW-1:0] off);
        return (base & ~(AW'(size) - AW'(1))) | AW'(off);
    endfunction

    assign last_off    = OW'(q.size - SW'(1));
    assign rd_off      = (q.st == S_PRD) ? last_off : q.idx;
    assign load_follow = (q.st == S_LOAD) && (q.idx != '0);

    // address and data presented to the bus engine; sampled when go is high
    always_comb begin
        b_wr   = (q.st == S_CMD) || (q.st == S_LOAD);
        b_data = buf_rd;
        case (q.st)
            S_CMD: begin
                b_addr = (q.idx == OW'(1)) ? AW'(16'h2AAA) : AW'(16'h5555);
                case (q.idx)
                    OW'(0):  b_data = DW'(8'hAA);
                    OW'(1):  b_data = DW'(8'h55);
                    default: b_data = (q.kind == K_ID_ON)  ? DW'(8'h90) :
                                      (q.kind == K_ID_OFF) ? DW'(8'hF0) : DW'(8'hA0);
                endcase
            end
            S_IDRD:  b_addr = AW'(1);
            S_PRD:   b_addr = sect_addr(q.base, q.size, last_off);
            default: b_addr = sect_addr(q.base, q.size, q.idx);
        endcase
    end

    always_comb begin
        d        = q;
        d.go     = 1'b0;
        d.tstart = 1'b0;
        d.tstop  = 1'b0;
        case (q.st)
            S_IDLE: if (start) begin
                d.busy     = 1'b1;
                d.done     = 1'b0;
                d.err_to   = 1'b0;
                d.err_vf   = 1'b0;
                d.fail_off = '0;
                d.base     = base_addr;
                d.idx      = '0;
                d.go       = 1'b1;
                d.st       = S_CMD;
                d.kind     = id_en ? K_ID_ON : K_UNLOCK;
            end
            S_CMD: if (b_done) begin
                if (q.idx == OW'(2)) begin
                    d.idx = '0;
                    case (q.kind)
                        K_ID_ON: begin
                            d.st     = S_TWC;
                            d.tstart = 1'b1;
                            d.tload  = TW'(TWC_CYC);
                        end
                        K_ID_OFF: begin
                            d.kind = K_UNLOCK;
                            d.go   = 1'b1;
                        end
                        default: begin
                            d.st = S_LOAD;
                            d.go = 1'b1;
                        end
                    endcase
                end else begin
                    d.idx = q.idx + OW'(1);
                    d.go  = 1'b1;
                end
            end
            S_TWC: if (t_exp) begin
                d.st = S_IDRD;
                d.go = 1'b1;
            end
            S_IDRD: if (b_done) begin
                d.size = size_from_code(b_rdata[1:0]);
                d.st   = S_CMD;
                d.kind = K_ID_OFF;
                d.idx  = '0;
                d.go   = 1'b1;
            end
            S_LOAD: if (b_done) begin
                if (q.idx == last_off) begin
                    d.st     = S_PCHK;
                    d.tstart = 1'b1;
                    d.tload  = TW'(WD_CYC);
                end else begin
                    d.idx = q.idx + OW'(1);
                    d.go  = 1'b1;
                end
            end
            S_PCHK: begin
                if (t_exp) begin
                    d.err_to = 1'b1;
                    d.st     = S_IDLE;
                    d.busy   = 1'b0;
                    d.done   = 1'b1;
                    d.tstop  = 1'b1;
                end else begin
                    d.st = S_PRD;
                    d.go = 1'b1;
                end
            end
            S_PRD: if (b_done) begin
                if (b_rdata == buf_rd) begin
                    d.st  = S_VRF;
                    d.idx = '0;
                    d.go  = 1'b1;
                end else begin
                    d.st = S_PCHK;
                end
            end
            S_VRF: if (b_done) begin
                if (b_rdata != buf_rd || q.idx == last_off) begin
                    d.err_vf   = (b_rdata != buf_rd);
                    d.fail_off = (b_rdata != buf_rd) ? q.idx : '0;
                    d.st       = S_IDLE;
                    d.busy     = 1'b0;
                    d.done     = 1'b1;
                    d.tstop    = 1'b1;
                end else begin
                    d.idx = q.idx + OW'(1);
                    d.go  = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: S_IDLE, kind: K_UNLOCK, size: SW'(DEF_SECT), default: '0};
        else        q <= d;
    end

    sprog_sector_buf #(.DEPTH(BUF_DEPTH), .DW(DW), .OW(OW)) u_buf (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_off(ld_off), .ld_data(ld_data),
        .rd_off(rd_off), .rd_data(buf_rd)
    );

    sprog_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(q.tstart), .stop(q.tstop), .load(q.tload),
        .expired(t_exp)
    );

    sprog_bus_cycle #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC)) u_bus (
        .clk(clk), .rst_n(rst_n), .go(q.go), .wr_i(b_wr), .addr_i(b_addr), .wdata_i(b_data),
        .din(mem_din), .addr_o(mem_addr), .dout(mem_dout), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
        .we_n(mem_we_n), .cyc_done(b_done), .rdata(b_rdata)
    );

    assign busy        = q.busy;
    assign done        = q.done;
    assign err_timeout = q.err_to;
    assign err_verify  = q.err_vf;
    assign fail_off    = q.fail_off;
endmodule

// File: rtl/sector_prog_chk.sv
module sector_prog_chk #(
    parameter int AW        = 15,
    parameter int DW        = 8,
    parameter int PULSE_CYC = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          err_timeout,
    input logic          err_verify,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dout,
    input logic          load_follow
);
    logic [7:0] lo_cnt_q, hi_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt_q <= '0;
            hi_cnt_q <= '0;
        end else if (!mem_we_n) begin
            hi_cnt_q <= '0;
            if (lo_cnt_q != 8'hFF) lo_cnt_q <= lo_cnt_q + 8'd1;
        end else begin
            lo_cnt_q <= '0;
            if (hi_cnt_q != 8'hFF) hi_cnt_q <= hi_cnt_q + 8'd1;
        end
    end

    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_we_n && mem_oe_n));

    p_strobe_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (lo_cnt_q == 8'(PULSE_CYC)));

    p_strobe_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mem_we_n) && !mem_ce_n) |-> ($stable(mem_addr) && $stable(mem_dout)));

    p_byte_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) && load_follow) |-> (hi_cnt_q <= 8'd4));

    p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> (done && !busy && mem_ce_n && mem_we_n && mem_oe_n));

    p_one_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_timeout && err_verify));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind sector_prog_ctrl sector_prog_chk #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err_timeout(err_timeout),
    .err_verify(err_verify), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .load_follow(load_follow)
);

// File: tb/sector_prog_ctrl_test.sv
module sector_prog_ctrl_test;
    localparam int AW = 15, DW = 8, DEPTH = 16, OW = 4;
    localparam int PULSE = 3, TWC = 20, WD = 600, GAPLIM = 40;

    logic clk = 0, rst_n = 0;
    logic ld_en = 0, start = 0, id_en = 0;
    logic [OW-1:0] ld_off = '0;
    logic [DW-1:0] ld_data = '0;
    logic [AW-1:0] base_addr = '0;
    logic busy, done, err_timeout, err_verify;
    logic [OW-1:0] fail_off;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout, mem_din;
    logic mem_ce_n, mem_oe_n, mem_we_n;

    always #10 clk = ~clk;

    sector_prog_ctrl #(.AW(AW), .DW(DW), .BUF_DEPTH(DEPTH), .DEF_SECT(8),
                       .PULSE_CYC(PULSE), .TWC_CYC(TWC), .WD_CYC(WD)) uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_off(ld_off), .ld_data(ld_data),
        .start(start), .id_en(id_en), .base_addr(base_addr), .busy(busy), .done(done),
        .err_timeout(err_timeout), .err_verify(err_verify), .fail_off(fail_off),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // ---------------- behavioural memory model ----------------
    logic [7:0] mem [64];
    logic [7:0] pend [64];
    logic       pend_v [64];
    logic [7:0] cmask [64];   // driven by the bench only
    logic [7:0] dev_code = 8'h00;
    int         prog_time = 150;
    int         abort_tok = 0, clr_tok = 0;

    int  m_abort_seen = 0, m_clr_seen = 0;
    int  cs = 0, gap = 0, prog_cnt = 0, lo_cnt = 0;
    logic armed = 0, loaded = 0, idmode = 0, prev_we = 1, prev_oe = 1;
    logic [AW-1:0] last_addr = '0;
    logic [7:0] last_data = '0;
    int  load_cnt = 0, max_gap = 0, bad_pulse = 0, poll_rd = 0, bad_poll = 0, wlog_n = 0;
    logic [AW-1:0] wlog_a [6];
    logic [7:0]    wlog_d [6];

    wire busy_rd = (armed && loaded) || (prog_cnt != 0);
    wire wev     = !prev_we && mem_we_n && !mem_ce_n && mem_oe_n;

    always_comb begin
        if (busy_rd)                          mem_din = {~last_data[7], last_data[6:0]};
        else if (idmode && mem_addr == 15'd0) mem_din = 8'h1F;
        else if (idmode && mem_addr == 15'd1) mem_din = dev_code;
        else                                  mem_din = mem[mem_addr[5:0]] ^ cmask[mem_addr[5:0]];
    end

    always @(posedge clk) begin
        prev_we <= mem_we_n;
        prev_oe <= mem_oe_n;
        if (!mem_we_n) begin
            lo_cnt <= lo_cnt + 1;
            if (mem_ce_n || !mem_oe_n) bad_pulse <= bad_pulse + 1;
        end else begin
            lo_cnt <= 0;
            if (!prev_we && lo_cnt != PULSE) bad_pulse <= bad_pulse + 1;
        end
        if (prev_oe && !mem_oe_n && !mem_ce_n && busy_rd) begin
            poll_rd <= poll_rd + 1;
            if (mem_addr != last_addr) bad_poll <= bad_poll + 1;
        end
        if (clr_tok != m_clr_seen) begin
            m_clr_seen <= clr_tok;
            wlog_n <= 0; load_cnt <= 0; max_gap <= 0; poll_rd <= 0; bad_poll <= 0;
        end else if (wev && wlog_n < 6) begin
            wlog_a[wlog_n] <= mem_addr;
            wlog_d[wlog_n] <= mem_dout;
            wlog_n <= wlog_n + 1;
        end
        if (abort_tok != m_abort_seen) begin
            m_abort_seen <= abort_tok;
            prog_cnt <= 0; armed <= 0; loaded <= 0; cs <= 0;
        end else if (prog_cnt != 0) begin
            prog_cnt <= prog_cnt - 1;
            if (prog_cnt == 1)
                for (int i = 0; i < 64; i++) if (pend_v[i]) mem[i] <= pend[i];
        end else if (armed && loaded && gap >= GAPLIM) begin
            prog_cnt <= prog_time;
            armed <= 0;
            loaded <= 0;
        end else if (wev) begin
            if (armed) begin
                pend[mem_addr[5:0]]   <= mem_dout;
                pend_v[mem_addr[5:0]] <= 1'b1;
                loaded    <= 1'b1;
                load_cnt  <= load_cnt + 1;
                last_addr <= mem_addr;
                last_data <= mem_dout;
                gap       <= 0;
                if (loaded && gap > max_gap) max_gap <= gap;
            end else begin
                case (cs)
                    0: cs <= (mem_addr == 15'h5555 && mem_dout == 8'hAA) ? 1 : 0;
                    1: cs <= (mem_addr == 15'h2AAA && mem_dout == 8'h55) ? 2 : 0;
                    default: begin
                        cs <= 0;
                        if (mem_addr == 15'h5555) begin
                            if (mem_dout == 8'hA0) begin
                                armed <= 1'b1;
                                for (int i = 0; i < 64; i++) pend_v[i] <= 1'b0;
                            end
                            if (mem_dout == 8'h90) idmode <= 1'b1;
                            if (mem_dout == 8'hF0) idmode <= 1'b0;
                        end
                    end
                endcase
            end
        end else if (armed && loaded) begin
            gap <= gap + 1;
        end
    end

    // ---------------- bench bookkeeping ----------------
    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed + i * 37);
    endfunction

    task automatic load_buf(input int seed);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            ld_en = 1; ld_off = OW'(i); ld_data = pat(seed, i);
        end
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic run_op(input bit use_id, input logic [AW-1:0] base, output int cyc);
        clr_tok++;
        @(negedge clk);
        base_addr = base; id_en = use_id; start = 1;
        @(negedge clk);
        start = 0;
        cyc = 1;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check(done == 1'b1, "R7 operation completes", int'(done), 1);
    endtask

    task automatic check_sector(input string req, input int seed, input int sbase, input int size);
        int bad = 0;
        for (int i = 0; i < size; i++) if (mem[(sbase + i) % 64] !== pat(seed, i)) bad++;
        check(bad == 0, req, bad, 0);
        check(load_cnt == size, req, load_cnt, size);
    endtask

    task automatic check_unlock_at(input int k);
        check(wlog_a[k] == 15'h5555 && wlog_d[k] == 8'hAA, "R2 unlock byte 1", int'(wlog_d[k]), 'hAA);
        check(wlog_a[k+1] == 15'h2AAA && wlog_d[k+1] == 8'h55, "R2 unlock byte 2", int'(wlog_d[k+1]), 'h55);
        check(wlog_a[k+2] == 15'h5555 && wlog_d[k+2] == 8'hA0, "R2 unlock byte 3", int'(wlog_d[k+2]), 'hA0);
    endtask

    task automatic t_reset();
        check(mem_ce_n && mem_we_n && mem_oe_n, "R1 bus idle after reset",
              int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
        check(!busy && !done && !err_timeout && !err_verify, "R1 status clear after reset",
              int'({busy, done, err_timeout, err_verify}), 0);
    endtask

    task automatic t_basic(input int seed, input logic [AW-1:0] base, input int sbase);
        int cyc;
        load_buf(seed);
        run_op(1'b0, base, cyc);
        check(!err_timeout && !err_verify, "R7 clean finish", int'({err_timeout, err_verify}), 0);
        check(mem_ce_n && mem_we_n && mem_oe_n && !busy, "R1 bus idle after finish",
              int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
        check_unlock_at(0);
        check_sector("R3 sector bytes at masked base", seed, sbase, 8);
        check(bad_pulse == 0, "R4 strobe shape", bad_pulse, 0);
        check(max_gap <= 8, "R5 byte-to-byte spacing", max_gap, 8);
        check(poll_rd > 0 && bad_poll == 0, "R6 polls last address", bad_poll, 0);
    endtask

    task automatic t_verify_err();
        int cyc;
        load_buf(91);
        cmask[6'h23] = 8'h10;
        cmask[6'h25] = 8'h01;
        run_op(1'b0, 15'h0120, cyc);
        check(err_verify == 1'b1 && !err_timeout, "R8 mismatch flagged", int'(err_verify), 1);
        check(fail_off == 4'd3, "R8 first failing offset", int'(fail_off), 3);
        cmask[6'h23] = 8'h00;
        cmask[6'h25] = 8'h00;
    endtask

    task automatic t_timeout();
        int cyc;
        load_buf(5);
        prog_time = 100000;
        run_op(1'b0, 15'h0108, cyc);
        check(err_timeout == 1'b1 && !err_verify, "R9 watchdog error", int'(err_timeout), 1);
        check(cyc >= WD, "R9 not before watchdog limit", cyc, WD);
        check(mem_ce_n && mem_we_n && mem_oe_n && !busy, "R9 bus idle after timeout",
              int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
        abort_tok++;
        prog_time = 150;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_ident(input logic [7:0] code, input int size, input int seed,
                           input logic [AW-1:0] base, input int sbase);
        int cyc;
        dev_code = code;
        load_buf(seed);
        run_op(1'b1, base, cyc);
        check(wlog_a[0] == 15'h5555 && wlog_d[0] == 8'hAA && wlog_a[1] == 15'h2AAA &&
              wlog_d[1] == 8'h55 && wlog_a[2] == 15'h5555 && wlog_d[2] == 8'h90,
              "R10 identification entry", int'(wlog_d[2]), 'h90);
        check(wlog_a[5] == 15'h5555 && wlog_d[5] == 8'hF0, "R10 identification exit",
              int'(wlog_d[5]), 'hF0);
        check(!idmode, "R10 device left id mode", int'(idmode), 0);
        check(!err_timeout && !err_verify, "R10 clean finish", int'({err_timeout, err_verify}), 0);
        check_sector("R10 size from device code", seed, sbase, size);
    endtask

    task automatic t_persist();
        int cyc;
        load_buf(200);
        run_op(1'b0, 15'h0034, cyc);
        check_unlock_at(0);
        check_sector("R10 size kept without id", 200, 'h30, 16);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'hFF; cmask[i] = 8'h00; pend[i] = 8'h00; pend_v[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic(17, 15'h0123, 'h20);      // base 0x123 masks to 0x120 for size 8
        t_basic(66, 15'h0149, 'h08);      // base 0x149 masks to 0x148
        t_verify_err();
        t_timeout();
        t_ident(8'h26, 16, 123, 15'h003B, 'h30);   // code[1:0]=2 -> 16 bytes at 0x30
        t_persist();
        t_ident(8'hBC, 4, 7, 15'h0026, 'h24);      // code[1:0]=0 -> 4 bytes at 0x24
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule